// File: doc/BRIEF.md
# Scan Chain Latency Test Sequencer

This block is the controller-side sequencer for a continuity and length test of a device's scan chain. When software-side logic asserts `start`, the sequencer holds the device in reset for a programmable number of test-clock cycles. After a programmable idle gap it launches one marker pulse on `scan_in`, and then counts test-clock cycles until the marker returns on `scan_out`. The returned signal is resynchronised through a two-flop stage. That synchroniser delay is removed from the count before it is reported.

The observation window is always run to its end, so that a stretched or repeated return pulse can be reported. The verdict is one of three results. Pass means exactly one clean single-cycle pulse arrived at the expected latency. Timeout means no pulse arrived inside the window. Error means the pulse was malformed or repeated. The verdict and the measured latency stay on the outputs until the next accepted start. The logic counts clock edges only, so it works at any test-clock rate.

The states are:
- IDLE: waiting for `start`.
- RESET: the device reset is held low for `RST_CYC` cycles.
- GAP: `GAP_CYC` cycles of settling.
- LAUNCH: two cycles in which the marker is driven.
- WAIT: the observation window.
- JUDGE: the verdict is registered.
- FINISH: a one-cycle `done`.

The transitions are:
- IDLE to RESET on `start`.
- RESET to GAP when its timer expires.
- GAP to LAUNCH when its timer expires.
- LAUNCH to WAIT after its second cycle.
- WAIT to JUDGE when the window ends.
- JUDGE to FINISH unconditionally.
- FINISH to IDLE unconditionally.

Top module: `scan_latency_tester`

## Requirements
- R1: After controller reset: `busy`, `done`, `pass`, `timeout_flag`, `error_flag` and `scan_in` are 0, `latency` is 0, and `dut_rst_n` is 1.
- R2: A `start` sampled high in IDLE drives `dut_rst_n` low for exactly `RST_CYC` clock periods. A `start` raised while `busy` is high is ignored: the run keeps its length and launches only one marker.
- R3: `scan_in` rises on a falling clock edge, `GAP_CYC` periods plus half a period after `dut_rst_n` returns high.
- R4: `scan_in` stays high for one and a half clock periods and falls on a rising clock edge.
- R5: Edge E0 is the first rising edge after `scan_in` rises, and E_k is the k-th rising edge after E0. If `scan_out` is high in the period that starts at E_L, then `latency` reports L. The two synchroniser cycles are already removed from this value.
- R6: `pass` is 1 only if exactly one single-cycle pulse arrives with L equal to `EXP_LEN`. When `pass` is 1, `timeout_flag` and `error_flag` are 0.
- R7: If no pulse starts with L at or below `TIMEOUT`, then `timeout_flag` is 1, `pass` is 0 and `latency` is 0.
- R8: A return pulse that is high for two consecutive periods inside the window sets `error_flag` and clears `pass`. `latency` still reports the pulse start.
- R9: A second rising pulse with L at or below `TIMEOUT` sets `error_flag` and clears `pass`. `latency` keeps the first pulse's L.
- R10: The `done` edge arrives `RST_CYC+GAP_CYC+TIMEOUT+5` rising edges after the accepting edge. `done` lasts one cycle, and `busy` is 0 while it is high. The verdict and `latency` then hold until the next start.
- R11: Pulses that start after the window (L above `TIMEOUT`) change neither the verdict nor the latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; any rate |
| rst_n | input | 1 | Active-low asynchronous controller reset |
| start | input | 1 | Begin a test when idle |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle completion strobe |
| pass | output | 1 | Chain length verified |
| timeout_flag | output | 1 | No return pulse inside the window |
| error_flag | output | 1 | Stretched or repeated return pulse |
| latency | output | LAT_W | Measured latency in clock cycles |
| dut_rst_n | output | 1 | Active-low reset to the device |
| scan_in | output | 1 | Marker pulse into the chain |
| scan_out | input | 1 | Chain output from the device |

## Verification
Two events can fall in the same cycle:
- The arrival of the return pulse and the close of the observation window. A pulse at L equal to `TIMEOUT` must still be counted, while one at `TIMEOUT+1` must give a timeout.
- A stretched or repeated pulse whose second half straddles the window end.

The bench sweeps every latency from 0 to `TIMEOUT+2` on a reduced configuration, and repeats the stretched and double pulses at the window edge. Each verdict is compared with a value derived arithmetically from L, the window size and the expected length.

// File: rtl/scan_lat_pkg.sv
package scan_lat_pkg;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESET,
        ST_GAP,
        ST_LAUNCH,
        ST_WAIT,
        ST_JUDGE,
        ST_FINISH
    } seq_state_t;
endpackage

// File: rtl/sl_sync.sv
module sl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[i] <= 1'b0;
                end else begin
                    if (i == 0) chain_q[i] <= din;
                    else        chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/sl_launch.sv
module sl_launch (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse
);
    logic armed_q;

    // Falling-edge capture: the pulse opens half a period into the fire
    // window and is closed by fire dropping on a rising edge.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= fire;
    end

    assign pulse = armed_q & fire;
endmodule

// File: rtl/sl_monitor.sv
module sl_monitor #(
    parameter int CNT_W = 11,
    parameter int LAT_W = 11,
    parameter int SYNC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             window,
    input  logic             sig,
    input  logic [CNT_W-1:0] count,
    output logic             seen,
    output logic             fault,
    output logic [LAT_W-1:0] first_lat
);
    logic prev_q;
    logic rise;

    assign rise = sig & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen      <= 1'b0;
            fault     <= 1'b0;
            first_lat <= '0;
        end else if (clear) begin
            seen      <= 1'b0;
            fault     <= 1'b0;
            first_lat <= '0;
        end else if (window) begin
            if (rise && !seen) begin
                seen      <= 1'b1;
                first_lat <= LAT_W'(count - CNT_W'(SYNC));
            end
            if ((rise && seen) || (sig && prev_q)) begin
                fault <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/scan_latency_tester.sv
module scan_latency_tester
    import scan_lat_pkg::*;
#(
    parameter  int EXP_LEN = 676,
    parameter  int RST_CYC = 4,
    parameter  int GAP_CYC = 4,
    parameter  int TIMEOUT = 1024,
    localparam int LAT_W   = $clog2(TIMEOUT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic             pass,
    output logic             timeout_flag,
    output logic             error_flag,
    output logic [LAT_W-1:0] latency,
    output logic             dut_rst_n,
    output logic             scan_in,
    input  logic             scan_out
);
    localparam int CNT_W   = $clog2(TIMEOUT + SYNC_STAGES + 1);
    localparam int TMR_MAX = (RST_CYC > GAP_CYC) ? RST_CYC : GAP_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam logic [CNT_W-1:0] WIN_END = CNT_W'(TIMEOUT + SYNC_STAGES);

    seq_state_t       state_q, state_d;
    logic [TMR_W-1:0] tmr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             phase_q;
    logic             pass_q, to_q, err_q;

    logic             launch_fire;
    logic             window;
    logic             clear_res;
    logic             ret_sync;
    logic             seen, fault;
    logic [LAT_W-1:0] first_lat;

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)           state_d = ST_RESET;
            ST_RESET:  if (tmr_q == '0)     state_d = ST_GAP;
            ST_GAP:    if (tmr_q == '0)     state_d = ST_LAUNCH;
            ST_LAUNCH: if (phase_q)         state_d = ST_WAIT;
            ST_WAIT:   if (cnt_q == WIN_END) state_d = ST_JUDGE;
            ST_JUDGE:                       state_d = ST_FINISH;
            ST_FINISH:                      state_d = ST_IDLE;
            default:                        state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- timers, counter, verdict ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q   <= '0;
            cnt_q   <= '0;
            phase_q <= 1'b0;
            pass_q  <= 1'b0;
            to_q    <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        tmr_q  <= TMR_W'(RST_CYC - 1);
                        pass_q <= 1'b0;
                        to_q   <= 1'b0;
                        err_q  <= 1'b0;
                    end
                end
                ST_RESET: begin
                    if (tmr_q == '0) tmr_q <= TMR_W'(GAP_CYC - 1);
                    else             tmr_q <= tmr_q - 1'b1;
                end
                ST_GAP: begin
                    if (tmr_q != '0) tmr_q <= tmr_q - 1'b1;
                    cnt_q   <= '0;
                    phase_q <= 1'b0;
                end
                ST_LAUNCH: begin
                    if (!phase_q) phase_q <= 1'b1;
                    else          cnt_q   <= cnt_q + 1'b1;
                end
                ST_WAIT: begin
                    cnt_q <= cnt_q + 1'b1;
                end
                ST_JUDGE: begin
                    pass_q <= seen & ~fault & (first_lat == LAT_W'(EXP_LEN));
                    to_q   <= ~seen;
                    err_q  <= fault;
                end
                ST_FINISH: begin
                end
                default: begin
                end
            endcase
        end
    end

    // ---------------- output decode ----------------
    always_comb begin
        busy        = !(state_q == ST_IDLE || state_q == ST_FINISH);
        done        = (state_q == ST_FINISH);
        dut_rst_n   = (state_q != ST_RESET);
        launch_fire = (state_q == ST_LAUNCH);
        window      = (state_q == ST_WAIT) && (cnt_q >= CNT_W'(SYNC_STAGES));
        clear_res   = (state_q == ST_IDLE) && start;
    end

    assign pass         = pass_q;
    assign timeout_flag = to_q;
    assign error_flag   = err_q;
    assign latency      = first_lat;

    sl_launch u_launch (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (launch_fire),
        .pulse (scan_in)
    );

    sl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (scan_out),
        .dout  (ret_sync)
    );

    sl_monitor #(.CNT_W(CNT_W), .LAT_W(LAT_W), .SYNC(SYNC_STAGES)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear_res),
        .window    (window),
        .sig       (ret_sync),
        .count     (cnt_q),
        .seen      (seen),
        .fault     (fault),
        .first_lat (first_lat)
    );
endmodule

// File: rtl/scan_latency_checker.sv
module scan_latency_checker #(
    parameter int LAT_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             pass,
    input logic             timeout_flag,
    input logic             error_flag,
    input logic [LAT_W-1:0] latency,
    input logic             dut_rst_n,
    input logic             scan_in,
    input logic             scan_out
);
    assert_rst_in_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dut_rst_n |-> busy);

    assert_marker_in_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        scan_in |-> (busy && dut_rst_n));

    assert_pass_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> (!timeout_flag && !error_flag));

    assert_timeout_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_flag |-> (latency == '0 && !pass));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(latency) && $stable(pass)
                               && $stable(timeout_flag) && $stable(error_flag)));
endmodule

bind scan_latency_tester scan_latency_checker #(.LAT_W(LAT_W)) u_chk (.*);

// File: tb/scan_latency_tester_test.sv
module scan_latency_tester_test;
    localparam int EXP = 20;
    localparam int RC  = 3;
    localparam int GC  = 2;
    localparam int TO  = 40;
    localparam int LW  = $clog2(TO + 1);
    localparam int M_NONE = 0, M_ONE = 1, M_LONG = 2, M_DOUBLE = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, done, pass, timeout_flag, error_flag, dut_rst_n, scan_in;
    logic scan_out = 1'b0;
    logic [LW-1:0] latency;

    int checks = 0;
    int failures = 0;
    int pl = 0, mode = M_NONE, gap2 = 3, n_sr = 0;
    time t_rf, t_rr, t_sr, t_sf;
    logic clk_at_rise, clk_at_fall;
    bit finished = 0;

    always #2 clk = ~clk;

    scan_latency_tester #(.EXP_LEN(EXP), .RST_CYC(RC), .GAP_CYC(GC), .TIMEOUT(TO)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .pass(pass), .timeout_flag(timeout_flag), .error_flag(error_flag),
        .latency(latency), .dut_rst_n(dut_rst_n), .scan_in(scan_in),
        .scan_out(scan_out)
    );

    always @(negedge dut_rst_n) t_rf = $time;
    always @(posedge dut_rst_n) t_rr = $time;
    always @(posedge scan_in) begin t_sr = $time; clk_at_rise = clk; n_sr++; end
    always @(negedge scan_in) begin t_sf = $time; clk_at_fall = clk; end

    // Device model: a chain that returns the marker L periods after E0.
    always begin
        @(posedge scan_in);
        if (mode != M_NONE) begin
            repeat (pl + 1) @(posedge clk);
            #1 scan_out = 1'b1;
            @(posedge clk);
            if (mode == M_LONG) @(posedge clk);
            #1 scan_out = 1'b0;
            if (mode == M_DOUBLE) begin
                repeat (gap2 - 1) @(posedge clk);
                #1 scan_out = 1'b1;
                @(posedge clk);
                #1 scan_out = 1'b0;
            end
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_test(input int l, input int md, input int g2, input bit poke);
        int cyc;
        bit seen, err, ps;
        logic [LW-1:0] lat_keep;
        pl = l; mode = md; gap2 = g2; n_sr = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cyc = 1;
        while (!done && cyc < 1000) begin
            @(negedge clk);
            cyc++;
            start = (poke && cyc == RC + GC + 5);
        end
        start = 1'b0;
        seen = (md != M_NONE) && (l <= TO);
        err  = seen && ((md == M_LONG && l + 1 <= TO) ||
                        (md == M_DOUBLE && l + g2 <= TO));
        ps   = seen && !err && (l == EXP);
        check("R10 run length", cyc, RC + GC + TO + 6);
        check("R10 busy low at done", busy, 0);
        check("R2 reset width", t_rr - t_rf, RC * 4);
        check("R3 gap to marker", t_sr - t_rr, GC * 4 + 2);
        check("R3 marker on falling edge", clk_at_rise, 0);
        check("R4 marker width", t_sf - t_sr, 6);
        check("R4 marker ends on rising edge", clk_at_fall, 1);
        check("R2 one marker per run", n_sr, 1);
        check("R5 latency", latency, seen ? l : 0);
        check("R6 pass", pass, ps);
        check("R7 timeout", timeout_flag, !seen);
        check((md == M_DOUBLE) ? "R9 error" : "R8 error", error_flag, err);
        lat_keep = latency;
        @(negedge clk);
        check("R10 done one cycle", done, 0);
        repeat (4) @(negedge clk);
        check("R10 latency held", latency, lat_keep);
        if (md == M_DOUBLE && l + g2 > TO) begin
            repeat (2 * TO) @(negedge clk);
            check("R11 late pulse ignored (latency)", latency, lat_keep);
            check("R11 late pulse ignored (error)", error_flag, 0);
            check("R11 late pulse ignored (pass)", pass, ps);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 pass", pass, 0);
        check("R1 scan_in", scan_in, 0);
        check("R1 dut_rst_n", dut_rst_n, 1);
        check("R1 latency", latency, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 flags after release", {timeout_flag, error_flag}, 0);

        // R5/R6/R7: sweep every latency across and past the window
        for (int l = 0; l <= TO + 2; l++) run_test(l, M_ONE, 3, 0);
        // R7: no return at all
        run_test(0, M_NONE, 3, 0);
        // R8: stretched pulse, inside and at the window edge
        run_test(EXP, M_LONG, 3, 0);
        run_test(5, M_LONG, 3, 0);
        run_test(TO, M_LONG, 3, 0);
        // R9: second pulse inside the window
        run_test(EXP, M_DOUBLE, 3, 0);
        run_test(TO - 3, M_DOUBLE, 3, 0);
        run_test(0, M_DOUBLE, 2, 0);
        // R11: second pulse after the window closes
        run_test(EXP, M_DOUBLE, TO + 3, 0);
        // R2: start raised mid-run is ignored
        run_test(EXP, M_ONE, 3, 1);
        run_test(EXP, M_ONE, 3, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule